// File: doc/BRIEF.md
# Segmented Address Translator

This block maps a 14-bit virtual address onto a 16-bit physical address through a four-entry segment table held in registers. The two most significant address bits pick an entry and the remaining twelve bits form an offset into that segment. Each entry stores a physical base, a length and three access-right bits.

On every request the block looks up the selected entry. It checks the offset against the length and the access kind against the rights. If both checks pass, it returns base plus offset. Otherwise it returns a zero address with a fault code. A write to a segment without the write right is reported as a distinct fault, so that system software can use it to trigger copy-on-write.

Entries are loaded through a simple write port that selects a segment, a field and a data value. Two entries may describe the same physical region with different rights, which lets a region be shared with different access levels. The response comes out one clock after the request.

Top module: `seg_xlate`

## Requirements
- R1: After reset, every entry has base 0, length 0 and no rights. `rsp_valid` is low and every request faults with cause 3 until entries are loaded.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. While `rsp_valid` is low, `rsp_paddr`, `rsp_cause` and `rsp_ok` are all zero.
- R3: A request that passes every check gives `rsp_ok`=1, `rsp_cause`=0 and `rsp_paddr` = (base + offset) mod 2^16.
- R4: An offset greater than or equal to the entry length gives cause 1 (bounds), `rsp_ok`=0 and `rsp_paddr`=0.
- R5: Rights bit 0 allows reads, bit 1 allows writes and bit 2 allows fetches. `req_kind` is 0 for read, 1 for write, 2 for fetch; kind 3 is never allowed. An access whose right is missing gives cause 2 (permission) with `rsp_paddr`=0. In particular, a write to a segment without the write right never produces an address.
- R6: When a request breaks both the bound and the rights, the cause is 1 (bounds takes priority over permission).
- R7: An entry with length 0 is invalid. Any request to it gives cause 3, ahead of both other causes.
- R8: A write on the configuration port with `cfg_field` 0 loads the base (16 bits), field 1 loads the length (low 13 bits of `cfg_data`) and field 2 loads the rights (low 3 bits). Field 3 changes nothing. A request sampled at the same clock edge as the write still sees the old value; a request sampled one edge later sees the new value.
- R9: The segment number is `req_vaddr[13:12]` and the offset is `req_vaddr[11:0]`. Two entries holding the same base and length but different rights translate to the same addresses, and each applies its own rights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 14 | Virtual address: segment number in the top 2 bits, offset in the low 12 |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| cfg_we | input | 1 | Segment table write strobe |
| cfg_seg | input | 2 | Entry to write |
| cfg_field | input | 2 | 0 base, 1 length, 2 rights, 3 no effect |
| cfg_data | input | 16 | Value for the selected field |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_paddr | output | 16 | Physical address, zero on a fault |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_cause | output | 2 | 0 none, 1 bounds, 2 permission, 3 invalid entry |

## Verification
Directed sequences come first. One probes the offsets just below, at and above a segment's length, which separates a correct bound from an off-by-one compare. Another sends each access kind to each rights combination, which exposes swapped rights bits. Requests that break several rules at once show whether the fault priority is right. Back-to-back configuration writes and requests show whether a new value takes effect at the correct edge. A long pseudo-random stream of mixed requests and table writes, including wrapping base-plus-offset sums and writes to the unused field, is then compared each cycle against a behavioural model of the table.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int VA_W  = 14,
  parameter int SEG_W = 2,
  parameter int PA_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic             cfg_we,
  input  logic [SEG_W-1:0] cfg_seg,
  input  logic [1:0]       cfg_field,
  input  logic [PA_W-1:0]  cfg_data,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_ok,
  output logic [1:0]       rsp_cause
);
  localparam int OFF_W = VA_W - SEG_W;
  localparam int NSEG  = 1 << SEG_W;
  localparam int LEN_W = OFF_W + 1;

  localparam logic [1:0] C_NONE  = 2'd0;
  localparam logic [1:0] C_BOUND = 2'd1;
  localparam logic [1:0] C_PERM  = 2'd2;
  localparam logic [1:0] C_INVAL = 2'd3;

  logic [PA_W-1:0]  base_q [NSEG];
  logic [LEN_W-1:0] len_q  [NSEG];
  logic [2:0]       perm_q [NSEG];

  for (genvar i = 0; i < NSEG; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        base_q[i] <= '0;
        len_q[i]  <= '0;
        perm_q[i] <= '0;
      end else if (cfg_we && cfg_seg == SEG_W'(i)) begin
        case (cfg_field)
          2'd0:    base_q[i] <= cfg_data;
          2'd1:    len_q[i]  <= cfg_data[LEN_W-1:0];
          2'd2:    perm_q[i] <= cfg_data[2:0];
          default: ;
        endcase
      end
    end
  end

  logic [SEG_W-1:0] seg;
  logic [OFF_W-1:0] off;
  logic [PA_W-1:0]  e_base;
  logic [LEN_W-1:0] e_len;
  logic [2:0]       e_perm;
  logic             allow, in_range;
  logic [1:0]       cause_d;

  assign seg      = req_vaddr[VA_W-1 -: SEG_W];
  assign off      = req_vaddr[OFF_W-1:0];
  assign e_base   = base_q[seg];
  assign e_len    = len_q[seg];
  assign e_perm   = perm_q[seg];
  assign in_range = {1'b0, off} < e_len;

  always_comb begin
    case (req_kind)
      2'd0:    allow = e_perm[0];
      2'd1:    allow = e_perm[1];
      2'd2:    allow = e_perm[2];
      default: allow = 1'b0;
    endcase
  end

  assign cause_d = (e_len == '0) ? C_INVAL :
                   !in_range     ? C_BOUND :
                   !allow        ? C_PERM  : C_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_ok    <= 1'b0;
      rsp_cause <= C_NONE;
    end else begin
      rsp_valid <= req_valid;
      rsp_ok    <= req_valid && cause_d == C_NONE;
      rsp_cause <= req_valid ? cause_d : C_NONE;
      rsp_paddr <= (req_valid && cause_d == C_NONE) ? e_base + PA_W'(off) : '0;
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_paddr == '0 && rsp_cause == C_NONE && !rsp_ok));
  p_fault_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |-> (rsp_paddr == '0 && rsp_cause != C_NONE));
  p_ro_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd1 && !e_perm[1] && e_len != '0 && in_range)
      |=> (rsp_cause == C_PERM && !rsp_ok));
  p_bound_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && e_len != '0 && !in_range) |=> rsp_cause == C_BOUND);
  p_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && e_len == '0) |=> rsp_cause == C_INVAL);
  p_len_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_field == 2'd1 && cfg_seg == '0) |=> len_q[0] == $past(cfg_data[LEN_W-1:0]));
endmodule

// File: tb/seg_xlate_tb.sv
`timescale 1ns/1ps
module seg_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [13:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_seg = '0;
  logic [1:0]  cfg_field = '0;
  logic [15:0] cfg_data = '0;
  logic        rsp_valid, rsp_ok;
  logic [15:0] rsp_paddr;
  logic [1:0]  rsp_cause;

  seg_xlate u_dut (.clk, .rst_n, .req_valid, .req_vaddr, .req_kind, .cfg_we,
    .cfg_seg, .cfg_field, .cfg_data, .rsp_valid, .rsp_paddr, .rsp_ok, .rsp_cause);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int m_base[4], m_len[4], m_perm[4];
  logic        e_valid = 0, e_ok = 0;
  logic [15:0] e_paddr = 0;
  logic [1:0]  e_cause = 0;
  string       e_tag = "R2";
  bit          have_exp = 0;

  task automatic compare();
    checks++;
    if (rsp_valid !== e_valid || rsp_ok !== e_ok || rsp_paddr !== e_paddr || rsp_cause !== e_cause) begin
      fails++;
      $display("FAIL %s: got v=%0b ok=%0b pa=%h c=%0d exp v=%0b ok=%0b pa=%h c=%0d",
               e_tag, rsp_valid, rsp_ok, rsp_paddr, rsp_cause, e_valid, e_ok, e_paddr, e_cause);
    end
  endtask

  task automatic tick(input bit rv, input int va, input int kd,
                      input bit we, input int sg, input int fd, input int dt, input string tag);
    int s, o, c;
    bit al;
    @(negedge clk);
    if (have_exp) compare();
    s = (va >> 12) & 3;
    o = va & 12'hfff;
    al = (kd == 0) ? m_perm[s][0] : (kd == 1) ? m_perm[s][1] : (kd == 2) ? m_perm[s][2] : 1'b0;
    c = (m_len[s] == 0) ? 3 : (o >= m_len[s]) ? 1 : !al ? 2 : 0;
    e_valid = rv;
    e_ok    = rv && c == 0;
    e_cause = rv ? 2'(c) : 2'd0;
    e_paddr = (rv && c == 0) ? 16'(m_base[s] + o) : 16'd0;
    if (tag != "") e_tag = tag;
    else e_tag = !rv ? "R2" : c == 3 ? "R7" : c == 1 ? "R4" : c == 2 ? "R5" : "R3";
    have_exp = 1;
    if (we) begin
      if (fd == 0) m_base[sg] = dt & 16'hffff;
      else if (fd == 1) m_len[sg] = dt & 13'h1fff;
      else if (fd == 2) m_perm[sg] = dt & 7;
    end
    req_valid = rv; req_vaddr = 14'(va); req_kind = 2'(kd);
    cfg_we = we; cfg_seg = 2'(sg); cfg_field = 2'(fd); cfg_data = 16'(dt);
  endtask

  task automatic wr(input int sg, input int fd, input int dt, input string tag);
    tick(0, 0, 0, 1, sg, fd, dt, tag);
  endtask

  task automatic rq(input int sg, input int o, input int kd, input string tag);
    tick(1, (sg << 12) | o, kd, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(8ns * 150000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_base[i] = 0; m_len[i] = 0; m_perm[i] = 0; end
    repeat (3) @(negedge clk);
    checks++;
    if (rsp_valid !== 0 || rsp_ok !== 0 || rsp_cause !== 0 || rsp_paddr !== 0) begin
      fails++; $display("FAIL R1: got v=%0b exp idle outputs", rsp_valid);
    end
    rst_n = 1'b1;
    for (int s = 0; s < 4; s++) rq(s, 0, 0, "R1");
    tick(0, 0, 0, 0, 0, 0, 0, "R2");
    // R8: same-edge request sees old length, next edge sees new
    tick(1, 12'h010, 0, 1, 0, 1, 256, "R8");
    tick(1, 12'h010, 0, 1, 0, 2, 1, "R8");
    rq(0, 12'h010, 0, "R8");
    wr(0, 0, 16'h4000, "R8");
    rq(0, 12'h010, 0, "R3");
    rq(0, 255, 0, "R4");
    rq(0, 256, 0, "R4");
    rq(0, 257, 0, "R4");
    rq(0, 12'h020, 1, "R5");
    rq(0, 12'h020, 2, "R5");
    rq(0, 12'h020, 3, "R5");
    rq(0, 300, 1, "R6");
    // R9: two entries sharing a region with different rights
    wr(1, 0, 16'h4000, "R9"); wr(1, 1, 256, "R9"); wr(1, 2, 3, "R9");
    rq(1, 12'h020, 1, "R9");
    rq(1, 12'h020, 0, "R9");
    rq(0, 12'h020, 0, "R9");
    // R8: field 3 leaves the entry unchanged
    wr(1, 3, 16'h0000, "R8");
    rq(1, 12'h020, 1, "R8");
    rq(1, 255, 0, "R8");
    // wrapping sum and full-length segment
    wr(2, 0, 16'hff00, "R3"); wr(2, 1, 4096, "R3"); wr(2, 2, 7, "R3");
    rq(2, 12'hfff, 2, "R3");
    rq(2, 12'h0ff, 1, "R3");
    rq(3, 12'h001, 0, "R7");
    for (int k = 0; k < 4000; k++) begin
      int r = $urandom;
      if (r[3:0] == 0) tick(r[4], r[31:18], r[6:5], 1, r[8:7], r[10:9], {5'd0, r[23:12]} | (r[11] ? 16'h1000 : 0), "");
      else tick(r[4] | r[5], r[31:18], r[7:6], 0, 0, 0, 0, "");
    end
    tick(0, 0, 0, 0, 0, 0, 0, "R2");
    @(negedge clk);
    compare();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule